// File: doc/BRIEF.md
# Phased Parallel Bus Cycle Generator

This block connects an internal host port that issues one request at a time to a parallel peripheral bus with a single chip select. An accepted request becomes one bus access. The access runs through five phases in a fixed order: address, setup, strobe, hold and recovery. Each phase lasts one clock plus an extension that is programmed separately for that phase. The address and setup extensions are 2-bit fields, so they range from 0 to 3 extra cycles. The strobe extension is a 4-bit field. The hold extension ranges from 0 to 3 extra cycles, and the recovery extension from 0 to 15.

The block drives the address, an active-low chip select, the strobe pins and a bidirectional 16-line data bus. Configuration inputs select the following at run time:
- an 8-bit or 16-bit data width;
- whether the address is placed on the data lines during the address phase;
- one of three strobe styles: split read/write strobes, a direction line with one data strobe, or split strobes that wait for a ready input of selectable polarity;
- whether writes are allowed;
- whether true byte reads are allowed on a 16-bit bus.

The host sees a request handshake and a one-cycle completion pulse. The pulse carries the read data and an error flag.

Top module: `extbus_cycle_gen`

## Requirements
- R1: A request is accepted at a clock edge where `reqValid` and `reqReady` are both high. From the next cycle the phases follow in order. Their lengths in cycles are 1+`cfgAddrExt` (address), 1+`cfgSetupExt` (setup), 1+`cfgStrobeExt` (strobe), 1+`cfgHoldExt` (hold) and 1+`cfgRecovExt` (recovery). In the wait-on-ready style the strobe phase can be longer, as R5 describes.
- R2: `busCsN` is low during the setup, strobe and hold phases. It is high during the address and recovery phases and while idle.
- R3: With `cfgCycleType` 0 or 3 (split strobes), `busRdN` goes low for a read and `busWrN` goes low for a write, only during the strobe phase. `busDsN` and `busRnW` stay high.
- R4: With `cfgCycleType` 1 (direction style), `busRnW` is low from the address phase through the hold phase of a write, and high otherwise. `busDsN` is low during the strobe phase. `busRdN` and `busWrN` stay high.
- R5: With `cfgCycleType` 2 (wait-on-ready), the strobes behave as in R3. The strobe phase ends at the first edge where its extension has elapsed and `busReady` equals `cfgReadyHigh`, so `cfgReadyHigh`=1 means ready is active high and 0 means active low.
- R6: With `cfgMux` set, data lines [15:0] carry the low 16 address bits during the address phase, for reads and writes and on either bus width.
- R7: A write drives data during the setup, strobe and hold phases. A halfword write on the 16-bit bus drives `reqWdata`. A byte write on the 16-bit bus drives `reqWdata[7:0]` on both lanes. On the 8-bit bus, only lines [7:0] are driven, with `reqWdata[7:0]`.
- R8: During a read the block drives no data line, except the address lines of R6. The data bus is sampled at the edge that ends the strobe phase. `rspRdata` holds the result from the cycle after recovery, which is the cycle in which `rspDone` is high.
- R9: When `cfgWrEn` is 0, an accepted write drives no chip select or strobe. `rspDone` and `rspErr` are both high in the next cycle, and the block stays ready.
- R10: With `cfgByteBus` set (8-bit bus), every access moves one byte on lines [7:0]. A read returns `{8'h00, data[7:0]}`.
- R11: On the 16-bit bus, `reqSize`=0 is a byte request and 1 is a halfword request. For a byte read with `cfgByteRdOk` clear, `busAddr[0]` is forced to 0. With `cfgByteRdOk` set, the request address is driven as given. A byte read returns the lane picked by `reqAddr[0]`, where 0 picks lines [7:0], zero-extended.
- R12: `reqReady` is high only while idle. This includes the cycle in which `rspDone` pulses, so a new request can start in that cycle. `rspErr` is low on completions that are not rejected writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Block idle and able to accept |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 1 | 0 = byte, 1 = halfword |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | 16 | Write data |
| rspDone | output | 1 | One-cycle completion pulse |
| rspErr | output | 1 | Completion was a rejected write |
| rspRdata | output | 16 | Read result |
| cfgAddrExt | input | SHORT_W | Address phase extension |
| cfgSetupExt | input | SHORT_W | Setup phase extension |
| cfgStrobeExt | input | LONG_W | Strobe phase extension |
| cfgHoldExt | input | SHORT_W | Hold phase extension |
| cfgRecovExt | input | LONG_W | Recovery phase extension |
| cfgCycleType | input | 2 | Strobe style: 0 split, 1 direction, 2 wait-on-ready, 3 as 0 |
| cfgReadyHigh | input | 1 | Ready polarity: 1 = active high |
| cfgMux | input | 1 | Address on data lines during address phase |
| cfgWrEn | input | 1 | Writes permitted |
| cfgByteBus | input | 1 | 8-bit bus when set |
| cfgByteRdOk | input | 1 | True byte reads allowed on 16-bit bus |
| busAddr | output | ADDR_W | Bus address |
| busCsN | output | 1 | Chip select, active low |
| busRdN | output | 1 | Read strobe, active low |
| busWrN | output | 1 | Write strobe, active low |
| busRnW | output | 1 | Direction line, low for write |
| busDsN | output | 1 | Data strobe, active low |
| busReady | input | 1 | Peripheral ready |
| busData | inout | 16 | Data bus |

## Verification
Completion and acceptance of the next request can fall in the same cycle. The `rspDone` pulse of one access appears in the very cycle in which `reqReady` returns high. The bench therefore raises the next request in the completion cycle, and it does this both after normal accesses and after a rejected write. The reference model then expects the address phase in the following cycle and no overlap of chip select or strobes. A second case is the wait-on-ready style, where the ready input and the expiry of the strobe extension can coincide. The bench varies the ready delay below, at and above the programmed extension, so both sources are seen closing the phase.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int DATA_W = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ADDR   = 3'd1,
    PH_SETUP  = 3'd2,
    PH_STROBE = 3'd3,
    PH_HOLD   = 3'd4,
    PH_RECOV  = 3'd5
  } phase_e;

  localparam logic [1:0] CT_DIR  = 2'd1;
  localparam logic [1:0] CT_HOST = 2'd2;
  localparam logic       SZ_BYTE = 1'b0;

  typedef struct packed {
    logic latchReq;   // take request fields into the datapath
    logic capture;    // sample read data this edge
    logic driveAddr;  // address phase is active
    logic driveData;  // write data window is active
  } dpCtrl_t;
endpackage

// File: rtl/ebc_ctrl.sv
module ebc_ctrl
  import ebc_pkg::*;
#(
  parameter int SHORT_W = 2,
  parameter int LONG_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [SHORT_W-1:0] cfgAddrExt,
  input  logic [SHORT_W-1:0] cfgSetupExt,
  input  logic [LONG_W-1:0]  cfgStrobeExt,
  input  logic [SHORT_W-1:0] cfgHoldExt,
  input  logic [LONG_W-1:0]  cfgRecovExt,
  input  logic [1:0]         cfgCycleType,
  input  logic               cfgReadyHigh,
  input  logic               cfgWrEn,
  input  logic               busReady,
  output logic               reqReady,
  output logic               rspDone,
  output logic               rspErr,
  output logic               busCsN,
  output logic               busRdN,
  output logic               busWrN,
  output logic               busRnW,
  output logic               busDsN,
  output dpCtrl_t            dpCtrl
);
  typedef logic [LONG_W-1:0] cnt_t;

  phase_e state, nextState;
  cnt_t   cnt, nextExt;
  logic   isWrite, doneQ, errQ;
  logic   accept, wrBlock, hostStyle, dirStyle, readyOk, phaseEnd, strobeOn, csOn;

  assign hostStyle = (cfgCycleType == CT_HOST);
  assign dirStyle  = (cfgCycleType == CT_DIR);
  assign readyOk   = (busReady == cfgReadyHigh);
  assign accept    = (state == PH_IDLE) && reqValid;
  assign wrBlock   = accept && reqWrite && !cfgWrEn;
  assign phaseEnd  = (cnt == '0) && !((state == PH_STROBE) && hostStyle && !readyOk);

  always_comb begin
    case (state)
      PH_ADDR:   begin nextState = PH_SETUP;  nextExt = cnt_t'(cfgSetupExt); end
      PH_SETUP:  begin nextState = PH_STROBE; nextExt = cfgStrobeExt;        end
      PH_STROBE: begin nextState = PH_HOLD;   nextExt = cnt_t'(cfgHoldExt);  end
      PH_HOLD:   begin nextState = PH_RECOV;  nextExt = cfgRecovExt;         end
      default:   begin nextState = PH_IDLE;   nextExt = '0;                  end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= PH_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
      doneQ   <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      errQ  <= 1'b0;
      if (state == PH_IDLE) begin
        if (wrBlock) begin
          doneQ <= 1'b1;
          errQ  <= 1'b1;
        end else if (accept) begin
          state   <= PH_ADDR;
          cnt     <= cnt_t'(cfgAddrExt);
          isWrite <= reqWrite;
        end
      end else if (phaseEnd) begin
        state <= nextState;
        cnt   <= nextExt;
        if (state == PH_RECOV) doneQ <= 1'b1;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign strobeOn = (state == PH_STROBE);
  assign csOn     = (state == PH_SETUP) || (state == PH_STROBE) || (state == PH_HOLD);

  assign reqReady = (state == PH_IDLE);
  assign rspDone  = doneQ;
  assign rspErr   = errQ;
  assign busCsN   = !csOn;
  assign busRdN   = !(strobeOn && !dirStyle && !isWrite);
  assign busWrN   = !(strobeOn && !dirStyle && isWrite);
  assign busDsN   = !(strobeOn && dirStyle);
  assign busRnW   = !(dirStyle && isWrite && (csOn || state == PH_ADDR));

  always_comb begin
    dpCtrl           = '0;
    dpCtrl.latchReq  = accept && !wrBlock;
    dpCtrl.capture   = strobeOn && phaseEnd && !isWrite;
    dpCtrl.driveAddr = (state == PH_ADDR);
    dpCtrl.driveData = isWrite && csOn;
  end

  function automatic phase_e succ(phase_e p);
    case (p)
      PH_IDLE:   return PH_ADDR;
      PH_ADDR:   return PH_SETUP;
      PH_SETUP:  return PH_STROBE;
      PH_STROBE: return PH_HOLD;
      PH_HOLD:   return PH_RECOV;
      default:   return PH_IDLE;
    endcase
  endfunction

  assert_phase_order_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == $past(state)) || (state == succ($past(state))));

  assert_ready_wait_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_STROBE && hostStyle && (busReady != cfgReadyHigh)) |=> (state == PH_STROBE));

  assert_reject_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspDone && $past(busCsN) && $past(busRdN) && $past(busWrN) && $past(busDsN)));

  assert_accept_starts_R12: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !(reqWrite && !cfgWrEn)) |=> (state == PH_ADDR && !reqReady));
endmodule

// File: rtl/ebc_datapath.sv
module ebc_datapath
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgMux,
  input  logic              cfgByteBus,
  input  logic              cfgByteRdOk,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSize,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  dpCtrl_t           dpCtrl,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] dataOe,
  output logic [DATA_W-1:0] rspRdata
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdQ, rdNext, wrWord, wrOe;
  logic              wrQ, byteQ, laneQ, narrowRead;
  logic [LANE_W-1:0] laneIn [LANES];

  assign narrowRead = !reqWrite && (reqSize == SZ_BYTE) && !cfgByteBus && !cfgByteRdOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      wrQ    <= 1'b0;
      byteQ  <= 1'b0;
      laneQ  <= 1'b0;
      rdQ    <= '0;
    end else begin
      if (dpCtrl.latchReq) begin
        addrQ  <= narrowRead ? {reqAddr[ADDR_W-1:1], 1'b0} : reqAddr;
        wdataQ <= reqWdata;
        wrQ    <= reqWrite;
        byteQ  <= (reqSize == SZ_BYTE);
        laneQ  <= reqAddr[0];
      end
      if (dpCtrl.capture) rdQ <= rdNext;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneIn[g] = dataIn[g*LANE_W +: LANE_W];
    assign wrWord[g*LANE_W +: LANE_W] = (byteQ || cfgByteBus) ? wdataQ[LANE_W-1:0]
                                                               : wdataQ[g*LANE_W +: LANE_W];
    assign wrOe[g*LANE_W +: LANE_W]   = (cfgByteBus && g != 0) ? '0 : '1;
  end

  always_comb begin
    if (cfgByteBus)  rdNext = DATA_W'(laneIn[0]);
    else if (byteQ)  rdNext = DATA_W'(laneIn[laneQ]);
    else             rdNext = dataIn;
  end

  always_comb begin
    dataOut = '0;
    dataOe  = '0;
    if (dpCtrl.driveAddr && cfgMux) begin
      dataOut = addrQ[DATA_W-1:0];
      dataOe  = '1;
    end else if (dpCtrl.driveData) begin
      dataOut = wrWord;
      dataOe  = wrOe;
    end
  end

  assign busAddr  = addrQ;
  assign rspRdata = rdQ;

  assert_read_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!wrQ && !dpCtrl.driveAddr) |-> (dataOe == '0));

  assert_narrow_lane_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgByteBus && dpCtrl.driveData) |-> (dataOe[DATA_W-1:LANE_W] == '0));

  assert_mux_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtrl.driveAddr && cfgMux) |-> (dataOe == '1 && dataOut == busAddr[DATA_W-1:0]));
endmodule

// File: rtl/extbus_cycle_gen.sv
module extbus_cycle_gen
  import ebc_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int SHORT_W = 2,
  parameter int LONG_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqWrite,
  input  logic               reqSize,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [15:0]        reqWdata,
  output logic               rspDone,
  output logic               rspErr,
  output logic [15:0]        rspRdata,
  input  logic [SHORT_W-1:0] cfgAddrExt,
  input  logic [SHORT_W-1:0] cfgSetupExt,
  input  logic [LONG_W-1:0]  cfgStrobeExt,
  input  logic [SHORT_W-1:0] cfgHoldExt,
  input  logic [LONG_W-1:0]  cfgRecovExt,
  input  logic [1:0]         cfgCycleType,
  input  logic               cfgReadyHigh,
  input  logic               cfgMux,
  input  logic               cfgWrEn,
  input  logic               cfgByteBus,
  input  logic               cfgByteRdOk,
  output logic [ADDR_W-1:0]  busAddr,
  output logic               busCsN,
  output logic               busRdN,
  output logic               busWrN,
  output logic               busRnW,
  output logic               busDsN,
  input  logic               busReady,
  inout  wire  [15:0]        busData
);
  dpCtrl_t           dpCtrl;
  logic [DATA_W-1:0] dataOut, dataOe, dataIn;

  ebc_ctrl #(.SHORT_W(SHORT_W), .LONG_W(LONG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .cfgAddrExt(cfgAddrExt), .cfgSetupExt(cfgSetupExt), .cfgStrobeExt(cfgStrobeExt),
    .cfgHoldExt(cfgHoldExt), .cfgRecovExt(cfgRecovExt), .cfgCycleType(cfgCycleType),
    .cfgReadyHigh(cfgReadyHigh), .cfgWrEn(cfgWrEn), .busReady(busReady),
    .reqReady(reqReady), .rspDone(rspDone), .rspErr(rspErr),
    .busCsN(busCsN), .busRdN(busRdN), .busWrN(busWrN), .busRnW(busRnW), .busDsN(busDsN),
    .dpCtrl(dpCtrl)
  );

  ebc_datapath #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .cfgMux(cfgMux), .cfgByteBus(cfgByteBus),
    .cfgByteRdOk(cfgByteRdOk), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .dpCtrl(dpCtrl), .dataIn(dataIn),
    .busAddr(busAddr), .dataOut(dataOut), .dataOe(dataOe), .rspRdata(rspRdata)
  );

  assign dataIn = busData;

  for (genvar i = 0; i < DATA_W; i++) begin : gPad
    assign busData[i] = dataOe[i] ? dataOut[i] : 1'bz;
  end
endmodule

// File: tb/tb_extbus_cycle_gen.sv
module tb_extbus_cycle_gen;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqSize = 1'b1;
  logic [AW-1:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic reqReady, rspDone, rspErr;
  logic [15:0] rspRdata;
  logic [1:0] cA = 0, cS = 0, cH = 0, cType = 0;
  logic [3:0] cT = 0, cR = 0;
  logic cRdyHi = 1, cMux = 0, cWrEn = 1, cByte = 0, cByteRd = 0;
  logic [AW-1:0] busAddr;
  logic busCsN, busRdN, busWrN, busRnW, busDsN, busReady;
  wire  [15:0] busData;

  logic [15:0] devVal = 16'hC35A;
  logic devOe, strobeSeen, readyAct;
  int strCnt = 0, rdyDelay = 0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // peripheral model
  assign devOe      = !busRdN || (!busDsN && busRnW);
  assign busData    = devOe ? devVal : 16'hzzzz;
  assign strobeSeen = !busRdN || !busWrN;
  assign readyAct   = strobeSeen && (strCnt >= rdyDelay);
  assign busReady   = cRdyHi ? readyAct : !readyAct;
  always @(posedge clk) strCnt <= strobeSeen ? strCnt + 1 : 0;

  extbus_cycle_gen #(.ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspDone(rspDone), .rspErr(rspErr), .rspRdata(rspRdata),
    .cfgAddrExt(cA), .cfgSetupExt(cS), .cfgStrobeExt(cT), .cfgHoldExt(cH),
    .cfgRecovExt(cR), .cfgCycleType(cType), .cfgReadyHigh(cRdyHi), .cfgMux(cMux),
    .cfgWrEn(cWrEn), .cfgByteBus(cByte), .cfgByteRdOk(cByteRd),
    .busAddr(busAddr), .busCsN(busCsN), .busRdN(busRdN), .busWrN(busWrN),
    .busRnW(busRnW), .busDsN(busDsN), .busReady(busReady), .busData(busData)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic setCfg(input int a, s, t, h, r, ct, rh, mux, we, bb, bro);
    cA = a[1:0]; cS = s[1:0]; cT = t[3:0]; cH = h[1:0]; cR = r[3:0];
    cType = ct[1:0]; cRdyHi = rh[0]; cMux = mux[0]; cWrEn = we[0];
    cByte = bb[0]; cByteRd = bro[0];
  endtask

  // pin vector: reqReady, rspDone, cs, rd, wr, ds, rnw
  function automatic logic [6:0] pinVec();
    return {reqReady, rspDone, busCsN, busRdN, busWrN, busDsN, busRnW};
  endfunction

  task automatic access(input string tag, input bit wr, input logic [AW-1:0] addr,
                        input bit size, input logic [15:0] wd, input int rdly);
    int  ct = (cType == 2'd3) ? 0 : int'(cType);
    bit  dir = (ct == 1), host = (ct == 2);
    logic [AW-1:0] eff = addr;
    int  len[5];
    logic [15:0] expRd;
    rdyDelay = rdly;
    if (!wr && size == 1'b0 && !cByte && !cByteRd) eff[0] = 1'b0;
    len[0] = 1 + int'(cA); len[1] = 1 + int'(cS);
    len[2] = host ? (((int'(cT) > rdly) ? int'(cT) : rdly) + 1) : 1 + int'(cT);
    len[3] = 1 + int'(cH); len[4] = 1 + int'(cR);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqSize = size; reqWdata = wd;
    chk(reqReady === 1'b1, "R12", "ready before accept", 32'(reqReady), 32'd1);
    @(negedge clk);
    reqValid = 1'b0;
    if (wr && !cWrEn) begin
      chk(pinVec() === 7'b1111111 && rspErr === 1'b1, tag, "rejected write pins/err",
          {24'd0, rspErr, pinVec()}, {24'd0, 8'hFF});
      return;
    end
    for (int p = 0; p < 5; p++) begin
      for (int c = 0; c < len[p]; c++) begin
        logic strobe = (p == 2);
        logic [6:0] ev;
        logic [15:0] ed;
        ev = {1'b0, 1'b0, !(p >= 1 && p <= 3), !(strobe && !dir && !wr),
              !(strobe && !dir && wr), !(strobe && dir), !(dir && wr && p <= 3)};
        if (p == 0 && cMux)            ed = eff[15:0];
        else if (wr && p >= 1 && p <= 3)
          ed = cByte ? {8'hzz, wd[7:0]} : (size == 1'b0 ? {wd[7:0], wd[7:0]} : wd);
        else if (!wr && strobe)        ed = devVal;
        else                           ed = 16'hzzzz;
        chk(pinVec() === ev, tag, $sformatf("pins phase %0d cyc %0d", p, c),
            32'(pinVec()), 32'(ev));
        chk(busAddr === eff, tag, "busAddr", 32'(busAddr), 32'(eff));
        chk(busData === ed, tag, $sformatf("busData phase %0d", p), 32'(busData), 32'(ed));
        @(negedge clk);
      end
    end
    chk(rspDone === 1'b1 && rspErr === 1'b0 && reqReady === 1'b1, "R12", "done cycle",
        {29'd0, rspDone, rspErr, reqReady}, 32'd5);
    if (!wr) begin
      if (cByte)             expRd = {8'h00, devVal[7:0]};
      else if (size == 1'b0) expRd = addr[0] ? {8'h00, devVal[15:8]} : {8'h00, devVal[7:0]};
      else                   expRd = devVal;
      chk(rspRdata === expRd, tag, "read data", 32'(rspRdata), 32'(expRd));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(pinVec() === 7'b1011111 && busData === 16'hzzzz, "R12", "reset state",
        32'(pinVec()), 32'h5F);
    // R3 split strobes, minimal timing, halfword write then read
    setCfg(0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0);
    access("R3", 1, 24'h001234, 1, 16'hBEEF, 0);
    access("R8", 0, 24'h001234, 1, 16'h0, 0);
    // R1 maximum extensions, back-to-back accept in the done cycle
    setCfg(3, 3, 15, 3, 15, 0, 1, 0, 1, 0, 0);
    access("R1", 0, 24'h00A0B0, 1, 16'h0, 0);
    access("R1", 1, 24'h00A0B2, 1, 16'h1357, 0);
    setCfg(1, 2, 3, 1, 2, 0, 1, 0, 1, 0, 0);
    access("R2", 1, 24'h000010, 1, 16'h2468, 0);
    // R4 direction style, with R6 multiplexed address
    setCfg(1, 1, 2, 1, 1, 1, 1, 1, 1, 0, 0);
    access("R4", 1, 24'h12ABCD, 1, 16'h55AA, 0);
    access("R6", 0, 24'h34FEDC, 1, 16'h0, 0);
    setCfg(0, 0, 1, 0, 0, 0, 1, 1, 1, 0, 0);
    access("R6", 1, 24'h00F00E, 1, 16'h7E7E, 0);
    // R5 wait-on-ready: ready late, ready early, low polarity
    setCfg(0, 0, 2, 0, 1, 2, 1, 0, 1, 0, 0);
    access("R5", 0, 24'h000200, 1, 16'h0, 6);
    access("R5", 1, 24'h000202, 1, 16'h0F0F, 1);
    setCfg(1, 0, 3, 0, 0, 2, 0, 0, 1, 0, 0);
    access("R5", 0, 24'h000204, 1, 16'h0, 3);
    access("R5", 1, 24'h000206, 1, 16'hA1A1, 9);
    // reserved cycle type behaves as split strobes
    setCfg(0, 1, 1, 0, 0, 3, 1, 0, 1, 0, 0);
    access("R3", 1, 24'h000300, 1, 16'h3C3C, 0);
    access("R3", 0, 24'h000302, 1, 16'h0, 0);
    // R9 writes disabled, then back-to-back read still works
    setCfg(0, 0, 1, 0, 1, 0, 1, 0, 0, 0, 0);
    access("R9", 1, 24'h000400, 1, 16'hDEAD, 0);
    access("R9", 1, 24'h000402, 1, 16'hDEAD, 0);
    access("R9", 0, 24'h000404, 1, 16'h0, 0);
    // R10 8-bit bus
    setCfg(0, 1, 1, 1, 0, 0, 1, 0, 1, 1, 0);
    access("R10", 1, 24'h000501, 1, 16'h9A7B, 0);
    access("R10", 0, 24'h000503, 1, 16'h0, 0);
    access("R10", 1, 24'h000504, 0, 16'h00C4, 0);
    // R11 byte accesses on the 16-bit bus
    setCfg(0, 0, 1, 0, 0, 0, 1, 1, 1, 0, 0);
    access("R11", 0, 24'h000601, 0, 16'h0, 0);
    access("R11", 0, 24'h000600, 0, 16'h0, 0);
    cByteRd = 1'b1;
    access("R11", 0, 24'h000601, 0, 16'h0, 0);
    access("R7", 1, 24'h000603, 0, 16'h1166, 0);
    @(negedge clk);
    chk(rspDone === 1'b0 && reqReady === 1'b1, "R12", "single done pulse",
        {30'd0, rspDone, reqReady}, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule